// File: doc/BRIEF.md
# Banked GPIO Controller with Implicit Output Enable

This block is a memory-mapped controller for a set of general-purpose pins, sized by parameter up to 128 pins. Pins are grouped into banks of 32. Each bank exposes four word registers. Software drives a pin high or low by writing a one to its bit in one of two write-one-to-act registers. Such a write also turns the pin into an output, so no separate direction write is needed. A third write-one-to-act register hands the pin back to input. A read-only register shows which pins are currently outputs.

Reading the level register returns pad levels after a two-flop synchronizer. The same synchronized levels drive one interrupt line per pin: pin n drives line n.

Shortly after reset is released, the synchronized levels of the low 64 pins are captured once. Software can read them back later as two words. The register bus is a single-cycle request port. Writes take effect at the clock edge that accepts them. Read data appears one cycle after the read request.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every pin is an input (`pad_oe_o` all zero) with output level zero (`pad_o` all zero), and the direction register of every bank reads zero.
- R2: Pin n lives in bank n/32 at bit n%32. Bank b occupies byte addresses 16*b to 16*b+15. Within a bank the offsets are: +0x0 level, +0x4 level-clear, +0x8 release, +0xC direction.
- R3: A write to the level register (+0x0) sets the output level of every pin whose data bit is one and makes that pin an output. Pins whose data bit is zero keep their level and direction.
- R4: A write to the level-clear register (+0x4) sets the output level of every pin whose data bit is one to zero and makes that pin an output. Pins whose data bit is zero are unchanged.
- R5: A write to the release register (+0x8) makes every pin whose data bit is one an input again. Its stored output level is kept. Pins whose data bit is zero are unchanged.
- R6: A read request is answered one cycle later, with `rvalid_o` high for exactly that cycle. A read of the level register (+0x0) returns the pad levels as seen through a two-stage synchronizer.
- R7: A read of the direction register (+0xC) returns 1 for each pin that is an output and 0 for each pin that is an input.
- R8: The synchronized levels of pins 0..31 and 32..63 are captured once after reset and read at byte addresses 0x40 and 0x44. Later pad changes and bus writes do not alter these words.
- R9: Bits of pins at or above the pin count (75 by default) read zero and ignore writes. Bank 3 reads all zero. The level-clear and release registers read zero, as does any unmapped address.
- R10: `irq_o[n]` follows pad n through the same synchronizer. A pad change is visible on `irq_o` after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| pad_i | input | NUM_PINS | Pad input levels |
| pad_o | output | NUM_PINS | Pad output levels |
| pad_oe_o | output | NUM_PINS | Pad output enables |
| irq_o | output | NUM_PINS | Per-pin interrupt lines (synchronized levels) |

## Verification
The bench targets the following corner cases and the failure each would expose:
- **Clearing a pin that is still an input.** A design that forgot to enable the driver on a clear would leave the pin floating.
- **A release after a drive.** A design that also reset the stored level would show a changed `pad_o`.
- **Writing all ones into the partly filled third bank and into the empty fourth bank.** A design without the pin mask would report phantom outputs.
- **Synchronizer latency.** The bench samples `irq_o` after one edge and after two edges, so a missing or extra stage shows up.
- **The captured words.** They are re-read after the pads change and after a write to their addresses, which exposes a capture that keeps following the pads.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int unsigned BANK_W     = 32;
  localparam int unsigned BANK_SEL_W = 2;
  localparam int unsigned BANK_SLOTS = 1 << BANK_SEL_W;
  localparam int unsigned CAP_SEL_W  = 4;
  localparam int unsigned CAP_SLOTS  = 1 << CAP_SEL_W;

  typedef enum logic [1:0] {
    REG_LVL     = 2'd0,
    REG_LVL_CLR = 2'd1,
    REG_REL     = 2'd2,
    REG_DIR     = 2'd3
  } bank_reg_e;

  function automatic logic [BANK_W-1:0] bank_mask(int unsigned bank, int unsigned pins);
    logic [BANK_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < BANK_W; i++)
      if (bank * BANK_W + i < pins) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_rstcap.sv
module gpio_rstcap #(
  parameter int unsigned W   = 64,
  parameter int unsigned LAT = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] smp_i,
  output logic [W-1:0] cap_o
);
  localparam int unsigned CW = $clog2(LAT + 1) + 1;
  localparam logic [CW-1:0] LAT_C = CW'(LAT);

  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [W-1:0]  cap_q;

  // wait until the synchronizer holds real pad data, then latch once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      cap_q  <= '0;
    end else if (!done_q) begin
      if (cnt_q == LAT_C) begin
        cap_q  <= smp_i;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cap_o = cap_q;

  a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);
  a_r8_capture_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> $stable(cap_q));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_ctrl_pkg::*;
#(
  parameter logic [BANK_W-1:0] IMPL = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic              rel_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] lvl_o,
  output logic [BANK_W-1:0] oe_o
);
  logic [BANK_W-1:0] wmask;
  logic [BANK_W-1:0] lvl_q, oe_q;

  assign wmask = wdata_i & IMPL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      oe_q  <= '0;
    end else if (set_i) begin
      lvl_q <= lvl_q | wmask;
      oe_q  <= oe_q | wmask;
    end else if (clr_i) begin
      lvl_q <= lvl_q & ~wmask;
      oe_q  <= oe_q | wmask;
    end else if (rel_i) begin
      oe_q  <= oe_q & ~wmask;
    end
  end

  assign lvl_o = lvl_q;
  assign oe_o  = oe_q;

  a_r3_set_drives_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((lvl_q & $past(wmask)) == $past(wmask)) && ((oe_q & $past(wmask)) == $past(wmask)));
  a_r4_clr_drives_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((lvl_q & $past(wmask)) == '0) && ((oe_q & $past(wmask)) == $past(wmask)));
  a_r5_release_keeps_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && !set_i && !clr_i) |=> ((oe_q & $past(wmask)) == '0) && $stable(lvl_q));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 75,
  parameter int unsigned CAP_PINS    = 64,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic                rvalid_o,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] irq_o
);
  localparam int unsigned NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam int unsigned CAP_WORDS = (CAP_PINS + BANK_W - 1) / BANK_W;
  localparam int unsigned FULL_W    = BANK_SLOTS * BANK_W;
  localparam int unsigned CAP_FW    = CAP_SLOTS * BANK_W;

  logic [NUM_PINS-1:0] pad_s;
  logic [CAP_PINS-1:0] cap;
  logic [FULL_W-1:0]   smp_full, lvl_full, oe_full;
  logic [CAP_FW-1:0]   cap_full;

  logic [BANK_W-1:0] smp_w [BANK_SLOTS];
  logic [BANK_W-1:0] lvl_w [BANK_SLOTS];
  logic [BANK_W-1:0] oe_w  [BANK_SLOTS];
  logic [BANK_W-1:0] cap_w [CAP_SLOTS];

  gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(pad_i), .q_o(pad_s)
  );

  gpio_rstcap #(.W(CAP_PINS), .LAT(SYNC_STAGES)) u_cap (
    .clk_i (clk_i), .rst_ni(rst_ni), .smp_i(pad_s[CAP_PINS-1:0]), .cap_o(cap)
  );

  assign irq_o = pad_s;

  // address decode
  logic                  hit, in_cap, wr;
  logic [BANK_SEL_W-1:0] bsel;
  logic [CAP_SEL_W-1:0]  csel;
  bank_reg_e             rsel;

  assign hit    = (addr_i >> 7) == '0;
  assign in_cap = addr_i[6];
  assign bsel   = addr_i[5:4];
  assign csel   = addr_i[5:2];
  assign rsel   = bank_reg_e'(addr_i[3:2]);
  assign wr     = req_i && we_i && hit && !in_cap;

  assign smp_full = FULL_W'(pad_s);
  assign cap_full = CAP_FW'(cap);

  for (genvar b = 0; b < int'(BANK_SLOTS); b++) begin : g_bank
    assign smp_w[b] = smp_full[b*BANK_W +: BANK_W];
    if (b < int'(NUM_BANKS)) begin : g_real
      logic sel;
      assign sel = wr && (bsel == BANK_SEL_W'(b));
      gpio_bank #(.IMPL(bank_mask(b, NUM_PINS))) u_bank (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (sel && rsel == REG_LVL),
        .clr_i  (sel && rsel == REG_LVL_CLR),
        .rel_i  (sel && rsel == REG_REL),
        .wdata_i(wdata_i),
        .lvl_o  (lvl_w[b]),
        .oe_o   (oe_w[b])
      );
    end else begin : g_none
      assign lvl_w[b] = '0;
      assign oe_w[b]  = '0;
    end
    assign lvl_full[b*BANK_W +: BANK_W] = lvl_w[b];
    assign oe_full[b*BANK_W +: BANK_W]  = oe_w[b];
  end

  for (genvar c = 0; c < int'(CAP_SLOTS); c++) begin : g_capw
    if (c < int'(CAP_WORDS)) begin : g_real
      assign cap_w[c] = cap_full[c*BANK_W +: BANK_W];
    end else begin : g_none
      assign cap_w[c] = '0;
    end
  end

  assign pad_o    = lvl_full[NUM_PINS-1:0];
  assign pad_oe_o = oe_full[NUM_PINS-1:0];

  // read path
  logic [31:0] rd_d, rdata_q;
  logic        rvalid_q, rd_req;

  assign rd_req = req_i && !we_i;

  always_comb begin
    rd_d = '0;
    if (hit) begin
      if (in_cap) rd_d = cap_w[csel];
      else begin
        unique case (rsel)
          REG_LVL: rd_d = smp_w[bsel];
          REG_DIR: rd_d = oe_w[bsel];
          default: rd_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_req;
      rdata_q  <= rd_req ? rd_d : '0;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  a_r6_read_answered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rvalid_o);
  a_r6_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rvalid_o);
  a_r9_unimpl_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lvl_full >> NUM_PINS) == '0) && ((oe_full >> NUM_PINS) == '0));
  a_r9_wr_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> !rvalid_o);
endmodule

// File: tb/gpio_bank_ctrl_test.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_test;
  localparam int NP = 75;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rvalid;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, irq;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit cmp_on = 0, finished = 0;
  logic [127:0] lvl_m = '0, oe_m = '0, pad_m = '0, init_m = '0;

  localparam logic [NP-1:0] INIT = 75'h5A5_C3C3_1234_F00F_A55A;
  localparam logic [NP-1:0] PAT2 = 75'h6F0_0FF0_9876_1111_2222;
  localparam logic [NP-1:0] PAT3 = 75'h10F_FFFF_0000_8001_7F7F;

  task automatic chk(input bit ok, input string req_s, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req_s, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      finish_run();
    end
  end

  // reference model compared every cycle
  always @(negedge clk) if (rst_n && cmp_on) begin
    chk(pad_out == lvl_m[NP-1:0], "R3/R4 pad_o", 128'(pad_out), 128'(lvl_m[NP-1:0]));
    chk(pad_oe == oe_m[NP-1:0], "R5/R7 pad_oe_o", 128'(pad_oe), 128'(oe_m[NP-1:0]));
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    req = 0; we = 0;
    if (a < 8'h40) begin
      for (int i = 0; i < 32; i++) begin
        int p;
        p = int'(a[5:4]) * 32 + i;
        if (p < NP && d[i]) begin
          case (a[3:2])
            2'd0: begin lvl_m[p] = 1'b1; oe_m[p] = 1'b1; end
            2'd1: begin lvl_m[p] = 1'b0; oe_m[p] = 1'b1; end
            2'd2: oe_m[p] = 1'b0;
            default: ;
          endcase
        end
      end
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    @(posedge clk);
    #1;
    req = 0;
    @(negedge clk);
    chk(rvalid === 1'b1, "R6 rvalid", 128'(rvalid), 128'(1));
    d = rdata;
    @(negedge clk);
    chk(rvalid === 1'b0, "R6 single valid", 128'(rvalid), 128'(0));
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string req_s);
    logic [31:0] d;
    rd(a, d);
    chk(d == e, req_s, 128'(d), 128'(e));
  endtask

  task automatic set_pads(input logic [NP-1:0] v);
    @(negedge clk);
    pad_in = v; pad_m = 128'(v);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    pad_in = INIT; pad_m = 128'(INIT); init_m = 128'(INIT);
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);

    // R1 reset state
    chk(pad_oe == '0, "R1 oe after reset", 128'(pad_oe), 0);
    chk(pad_out == '0, "R1 level after reset", 128'(pad_out), 0);
    cmp_on = 1;
    for (int b = 0; b < 3; b++) rd_chk(8'(b*16 + 12), 32'h0, "R1 dir reg");

    // R8 capture
    rd_chk(8'h40, init_m[31:0], "R8 capture low");
    rd_chk(8'h44, init_m[63:32], "R8 capture high");

    // R6 level read of synchronized pads, R9 masking of bank 2 upper bits
    set_pads(PAT2);
    for (int b = 0; b < 3; b++) rd_chk(8'(b*16), pad_m[b*32 +: 32], "R6 level read");
    rd_chk(8'h40, init_m[31:0], "R8 capture frozen");
    rd_chk(8'h44, init_m[63:32], "R8 capture frozen");
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h44, 32'h0);
    rd_chk(8'h40, init_m[31:0], "R8 capture write ignored");
    rd_chk(8'h44, init_m[63:32], "R8 capture write ignored");

    // R3 set
    wr(8'h00, 32'h0000_00F1);
    rd_chk(8'h0C, oe_m[31:0], "R7 dir after set");
    wr(8'h00, 32'h0000_0100);
    rd_chk(8'h0C, oe_m[31:0], "R3 zero bits unchanged");

    // R4 clear on an input pin
    wr(8'h14, 32'h8000_0003);
    chk(pad_oe[63] && !pad_out[63], "R4 clear enables low", 128'({pad_oe[63], pad_out[63]}), 128'(2'b10));
    rd_chk(8'h1C, oe_m[63:32], "R7 dir bank1");

    // R2 pin 40 -> bank1 bit 8
    wr(8'h10, 32'h0000_0100);
    @(negedge clk);
    chk(pad_out[40] && pad_oe[40], "R2 pin mapping", 128'({pad_out[40], pad_oe[40]}), 128'(2'b11));

    // R5 release keeps level
    wr(8'h08, 32'h0000_0011);
    @(negedge clk);
    chk(!pad_oe[0] && pad_out[0], "R5 release keeps level", 128'({pad_oe[0], pad_out[0]}), 128'(2'b01));
    rd_chk(8'h0C, oe_m[31:0], "R5 dir after release");
    wr(8'h04, 32'h0000_0001);
    rd_chk(8'h0C, oe_m[31:0], "R4 clear after release");

    // R9 partial bank 2 and empty bank 3
    wr(8'h20, 32'hFFFF_FFFF);
    rd_chk(8'h2C, 32'h0000_07FF, "R9 bank2 dir mask");
    wr(8'h30, 32'hFFFF_FFFF);
    rd_chk(8'h30, 32'h0, "R9 bank3 level");
    rd_chk(8'h3C, 32'h0, "R9 bank3 dir");
    rd_chk(8'h04, 32'h0, "R9 clear reads zero");
    rd_chk(8'h08, 32'h0, "R9 release reads zero");
    rd_chk(8'h48, 32'h0, "R9 unmapped");
    rd_chk(8'h80, 32'h0, "R9 out of range");
    wr(8'h28, 32'hFFFF_FFFF);
    rd_chk(8'h2C, 32'h0, "R9 bank2 released");

    // R10 interrupt latency
    @(negedge clk);
    pad_in = PAT3;
    @(negedge clk);
    chk(irq == PAT2, "R10 one edge", 128'(irq), 128'(PAT2));
    @(negedge clk);
    chk(irq == PAT3, "R10 two edges", 128'(irq), 128'(PAT3));
    pad_m = 128'(PAT3);
    @(negedge clk);
    for (int b = 0; b < 3; b++) rd_chk(8'(b*16), pad_m[b*32 +: 32], "R6 level read 2");

    repeat (3) @(negedge clk);
    finished = 1;
    finish_run();
  end
endmodule